// File: doc/BRIEF.md
# I2C interrupt status and clear unit

This block is the interrupt section of an I2C controller. It captures twelve interrupt sources into a raw status word and combines that word with a mask. It drives one interrupt line that is high while any unmasked source is pending. Ten of the sources are sticky. They are set by one-cycle event pulses from the bus engine and stay set until software reads a clear address.

The other two sources are not sticky. They follow the TX and RX FIFO fill levels against thresholds that software programs. They drop by themselves once the level condition is no longer met.

Software reaches the block through a simple register port with a one-cycle read or write strobe, an address and data. Clearing works by reading, never by writing. Each sticky source has its own clear address, and one further address clears all sticky sources at once.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: While reset is asserted, the raw status, the mask and both thresholds are zero and `irq_o` is low.
- R2: An event pulse on a sticky source (bits 0 rx-underflow, 1 rx-overflow, 3 tx-overflow, 5 read-request, 6 tx-abort, 7 rx-done, 8 activity, 9 stop-seen, 10 start-seen, 11 general-call) sets that bit of the raw status (address 0x34) at the next clock edge. The bit then holds.
- R3: A read of address 0x44 + 4·k clears only the k-th sticky source, where k counts the sticky bits upward from bit 0 (0x44 bit 0 up to 0x68 bit 11). The bit is clear from the next clock edge.
- R4: A read of address 0x40 clears every sticky source at the next clock edge.
- R5: When a sticky source receives an event in the same cycle as a read that clears it, the bit stays set.
- R6: Raw bit 4 (tx-empty) is 1 exactly while the TX level is at or below the TX threshold (address 0x3C), one cycle behind the inputs. No clear read affects it.
- R7: Raw bit 2 (rx-full) is 1 exactly while the RX level is above the RX threshold (address 0x38), one cycle behind the inputs. With threshold 0, one stored byte is enough to set it.
- R8: The mask (address 0x30) reads back as written. The masked status (address 0x2C) reads as the raw status AND the mask.
- R9: `irq_o` is high exactly when the masked status is non-zero.
- R10: Writes to 0x2C, 0x34, 0x40 and 0x44..0x68 change no state. Reads of 0x40..0x68 return 0.
- R11: Event pulses on bits 2 and 4 have no effect. Those bits follow only the FIFO levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| evt_i | input | 12 | One-cycle event pulses, one per source bit |
| tx_level_i | input | LVL_W (6) | Current TX FIFO fill level |
| rx_level_i | input | LVL_W (6) | Current RX FIFO fill level |
| reg_addr_i | input | ADDR_W (8) | Register byte address |
| reg_rd_i | input | 1 | Read strobe, one cycle per access |
| reg_wr_i | input | 1 | Write strobe, one cycle per access |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt line |

## Verification
A new event and a clear-on-read can target the same sticky bit in the same cycle. The bench provokes this by issuing each per-source clear read, and the combined clear read, while pulsing the event for the same bit. It then reads the raw status back and expects the bit still set, as R5 requires. A second collision, between a clear-all read and the level-following bits, is judged by reading raw status after the clear and expecting the tx-empty bit unchanged.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  localparam int ADDR_W = 8;
  localparam int NSRC   = 12;
  localparam int NCLR   = NSRC - 2;

  localparam int BIT_RX_FULL  = 2;
  localparam int BIT_TX_EMPTY = 4;

  localparam logic [NSRC-1:0] LEVEL_MASK = NSRC'((1 << BIT_RX_FULL) | (1 << BIT_TX_EMPTY));
  localparam logic [NSRC-1:0] LATCH_MASK = ~LEVEL_MASK;

  localparam int OFS_MSTAT  = 'h2C;
  localparam int OFS_MASK   = 'h30;
  localparam int OFS_RAW    = 'h34;
  localparam int OFS_RXTHR  = 'h38;
  localparam int OFS_TXTHR  = 'h3C;
  localparam int OFS_CLRALL = 'h40;
  localparam int OFS_CLR0   = 'h44;
  localparam int OFS_CLRTOP = OFS_CLR0 + 4 * (NCLR - 1);

  // Map a read address onto the set of sticky bits it clears.
  function automatic logic [NSRC-1:0] clr_decode(input logic [ADDR_W-1:0] a);
    logic [NSRC-1:0] v;
    int              k;
    v = '0;
    k = 0;
    if (a == ADDR_W'(OFS_CLRALL)) v = LATCH_MASK;
    for (int i = 0; i < NSRC; i++) begin
      if (LATCH_MASK[i]) begin
        if (a == ADDR_W'(OFS_CLR0 + 4 * k)) v[i] = 1'b1;
        k++;
      end
    end
    return v;
  endfunction

  function automatic logic is_clr_addr(input logic [ADDR_W-1:0] a);
    return (a >= ADDR_W'(OFS_CLRALL)) && (a <= ADDR_W'(OFS_CLRTOP)) && (a[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/i2c_irq_cfg.sv
module i2c_irq_cfg
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NSRC-1:0]   mask_o,
  output logic [LVL_W-1:0]  rx_thr_o,
  output logic [LVL_W-1:0]  tx_thr_o
);

  logic [NSRC-1:0]  mask_q,   mask_d;
  logic [LVL_W-1:0] rx_thr_q, rx_thr_d;
  logic [LVL_W-1:0] tx_thr_q, tx_thr_d;
  logic             mask_en, rx_en, tx_en;

  always_comb begin
    mask_en  = wr_i && (addr_i == ADDR_W'(OFS_MASK));
    rx_en    = wr_i && (addr_i == ADDR_W'(OFS_RXTHR));
    tx_en    = wr_i && (addr_i == ADDR_W'(OFS_TXTHR));
    mask_d   = wdata_i[NSRC-1:0];
    rx_thr_d = wdata_i[LVL_W-1:0];
    tx_thr_d = wdata_i[LVL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_thr_q <= '0;
    end else if (rx_en) begin
      rx_thr_q <= rx_thr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_q <= '0;
    end else if (tx_en) begin
      tx_thr_q <= tx_thr_d;
    end
  end

  assign mask_o   = mask_q;
  assign rx_thr_o = rx_thr_q;
  assign tx_thr_o = tx_thr_q;

endmodule

// File: rtl/i2c_irq_lvl.sv
module i2c_irq_lvl #(
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  output logic             tx_hit_o,
  output logic             rx_hit_o
);

  always_comb begin
    tx_hit_o = (tx_level_i <= tx_thr_i);
    rx_hit_o = (rx_level_i >  rx_thr_i);
  end

endmodule

// File: rtl/i2c_irq_src.sv
module i2c_irq_src
  import i2c_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            tx_hit_i,
  input  logic            rx_hit_i,
  output logic [NSRC-1:0] raw_o
);

  logic [NSRC-1:0] raw_q;
  logic            unused_src;

  assign unused_src = ^{evt_i & LEVEL_MASK, clr_i & LEVEL_MASK};

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (LATCH_MASK[i]) begin : g_sticky
      logic nxt, en;
      always_comb begin
        en  = evt_i[i] | clr_i[i];
        nxt = evt_i[i];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          raw_q[i] <= 1'b0;
        end else if (en) begin
          raw_q[i] <= nxt;
        end
      end
    end else begin : g_level
      logic nxt;
      always_comb begin
        nxt = (i == BIT_TX_EMPTY) ? tx_hit_i : rx_hit_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          raw_q[i] <= 1'b0;
        end else begin
          raw_q[i] <= nxt;
        end
      end
    end
  end

  assign raw_o = raw_q;

endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);

  logic [NSRC-1:0]  mask_q;
  logic [LVL_W-1:0] rx_thr_q, tx_thr_q;
  logic [NSRC-1:0]  raw_q;
  logic [NSRC-1:0]  masked;
  logic [NSRC-1:0]  clr_vec;
  logic             tx_hit, rx_hit;

  i2c_irq_cfg #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .mask_o   (mask_q),
    .rx_thr_o (rx_thr_q),
    .tx_thr_o (tx_thr_q)
  );

  i2c_irq_lvl #(.LVL_W(LVL_W)) u_lvl (
    .tx_level_i (tx_level_i),
    .rx_level_i (rx_level_i),
    .tx_thr_i   (tx_thr_q),
    .rx_thr_i   (rx_thr_q),
    .tx_hit_o   (tx_hit),
    .rx_hit_o   (rx_hit)
  );

  always_comb begin
    clr_vec = reg_rd_i ? clr_decode(reg_addr_i) : '0;
  end

  i2c_irq_src u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .clr_i    (clr_vec),
    .tx_hit_i (tx_hit),
    .rx_hit_i (rx_hit),
    .raw_o    (raw_q)
  );

  always_comb begin
    masked = raw_q & mask_q;
    irq_o  = |masked;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(OFS_MSTAT): reg_rdata_o[NSRC-1:0]  = masked;
      ADDR_W'(OFS_MASK):  reg_rdata_o[NSRC-1:0]  = mask_q;
      ADDR_W'(OFS_RAW):   reg_rdata_o[NSRC-1:0]  = raw_q;
      ADDR_W'(OFS_RXTHR): reg_rdata_o[LVL_W-1:0] = rx_thr_q;
      ADDR_W'(OFS_TXTHR): reg_rdata_o[LVL_W-1:0] = tx_thr_q;
      default:            reg_rdata_o            = '0;
    endcase
  end

endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   evt_i,
  input logic [LVL_W-1:0]  tx_level_i,
  input logic [LVL_W-1:0]  rx_level_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [NSRC-1:0]   raw_q,
  input logic [NSRC-1:0]   mask_q,
  input logic [LVL_W-1:0]  rx_thr_q,
  input logic [LVL_W-1:0]  tx_thr_q
);

  // R2
  p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & LATCH_MASK) != '0) |=> ((raw_q & $past(evt_i & LATCH_MASK)) == $past(evt_i & LATCH_MASK)));

  // R3
  p_single_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_W'(OFS_CLR0) && !evt_i[0]) |=> !raw_q[0]);

  // R4
  p_clear_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_W'(OFS_CLRALL) && evt_i == '0) |=> ((raw_q & LATCH_MASK) == '0));

  // R5
  p_event_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && is_clr_addr(reg_addr_i) && evt_i[11]) |=> raw_q[11]);

  // R6
  p_tx_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_i <= tx_thr_q && !(reg_wr_i && reg_addr_i == ADDR_W'(OFS_TXTHR))) |=> raw_q[BIT_TX_EMPTY]);

  // R7
  p_rx_thr0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_thr_q == '0 && rx_level_i != '0 && !(reg_wr_i && reg_addr_i == ADDR_W'(OFS_RXTHR))) |=> raw_q[BIT_RX_FULL]);

  // R9
  p_irq_needs_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  // R10
  p_clr_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && is_clr_addr(reg_addr_i)) |-> (reg_rdata_o == '0));

  // R10
  p_raw_write_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(OFS_RAW) && evt_i == '0 && !reg_rd_i) |=> ((raw_q & LATCH_MASK) == ($past(raw_q) & LATCH_MASK)));

  logic unused_chk;
  assign unused_chk = ^{rx_level_i, rx_thr_q};

endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .tx_level_i  (tx_level_i),
  .rx_level_i  (rx_level_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .raw_q       (raw_q),
  .mask_q      (mask_q),
  .rx_thr_q    (rx_thr_q),
  .tx_thr_q    (tx_thr_q)
);

// File: tb/i2c_irq_ctrl_tb_top.sv
module i2c_irq_ctrl_tb_top;

  localparam int LW = 6;
  localparam logic [11:0] STICKY = 12'hFEB;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] evt;
  logic [LW-1:0] txl, rxl;
  logic [7:0]  addr;
  logic        rd, wr;
  logic [31:0] wdata, rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  i2c_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .tx_level_i(txl), .rx_level_i(rxl),
    .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rdx(input logic [7:0] a, input logic [11:0] ev, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1; evt = ev;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0; evt = '0;
  endtask

  task automatic wrx(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] ev);
    @(negedge clk); evt = ev;
    @(negedge clk); evt = '0;
  endtask

  function automatic logic [7:0] clr_addr(input int bitn);
    int k = 0;
    for (int j = 0; j < bitn; j++) if (STICKY[j]) k++;
    return 8'(8'h44 + 4 * k);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [11:0] m;
    rst_n = 1'b0; evt = '0; txl = 6'd5; rxl = '0; addr = '0; rd = 0; wr = 0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1: state visible before any clock edge out of reset
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    rdx(8'h34, '0, d); chk("R1 raw", d, 32'd0);
    rdx(8'h30, '0, d); chk("R1 mask", d, 32'd0);
    rdx(8'h38, '0, d); chk("R1 rxthr", d, 32'd0);
    rdx(8'h3C, '0, d); chk("R1 txthr", d, 32'd0);

    // R2 / R3 / R10 sweep over every sticky bit
    for (int i = 0; i < 12; i++) begin
      if (STICKY[i]) begin
        pulse(12'(1 << i));
        rdx(8'h34, '0, d); chk("R2 set", d, 32'(1 << i));
        rdx(clr_addr(i), '0, d); chk("R10 clr read zero", d, 32'd0);
        rdx(8'h34, '0, d); chk("R3 cleared", d, 32'd0);
        pulse(STICKY);
        rdx(clr_addr(i), '0, d);
        rdx(8'h34, '0, d); chk("R3 only one", d, 32'(STICKY & ~(12'(1 << i))));
        rdx(8'h40, '0, d); chk("R10 clrall zero", d, 32'd0);
        rdx(8'h34, '0, d); chk("R4 all cleared", d, 32'd0);
        // R5: event and clear in the same cycle
        rdx(clr_addr(i), 12'(1 << i), d);
        rdx(8'h34, '0, d); chk("R5 event wins", d, 32'(1 << i));
        rdx(8'h40, 12'(1 << i), d);
        rdx(8'h34, '0, d); chk("R5 event wins all", d, 32'(1 << i));
        rdx(8'h40, '0, d);
      end
    end

    // R11: event pulses on level bits are ignored
    pulse(12'h014);
    rdx(8'h34, '0, d); chk("R11 level evt ignored", d, 32'd0);

    // R6: tx-empty level sweep
    wrx(8'h3C, 32'd3);
    for (int t = 0; t < 8; t++) begin
      @(negedge clk); txl = LW'(t);
      @(negedge clk);
      rdx(8'h34, '0, d); chk("R6 tx level", d, (t <= 3) ? 32'h10 : 32'h0);
    end
    txl = '0;
    rdx(8'h40, '0, d);
    rdx(8'h34, '0, d); chk("R6 not clearable", d, 32'h10);
    txl = 6'd5;

    // R7: rx-full level sweep with two thresholds
    for (int th = 0; th <= 2; th += 2) begin
      wrx(8'h38, 32'(th));
      for (int r = 0; r < 5; r++) begin
        @(negedge clk); rxl = LW'(r);
        @(negedge clk);
        rdx(8'h34, '0, d); chk("R7 rx level", d, (r > th) ? 32'h4 : 32'h0);
      end
    end
    rxl = '0;
    @(negedge clk); @(negedge clk);

    // R8 / R9: mask sweep with all sticky bits pending
    pulse(STICKY);
    for (int n = 0; n < 6; n++) begin
      case (n)
        0: m = 12'h000; 1: m = 12'h001; 2: m = 12'h800;
        3: m = 12'h014; 4: m = 12'hFFF; default: m = 12'h5A5;
      endcase
      wrx(8'h30, {20'd0, m});
      rdx(8'h30, '0, d); chk("R8 mask readback", d, {20'd0, m});
      rdx(8'h2C, '0, d); chk("R8 masked", d, {20'd0, m & STICKY});
      chk("R9 irq", {31'd0, irq}, {31'd0, |(m & STICKY)});
    end

    // R10: writes to status and clear addresses change nothing
    wrx(8'h34, 32'd0); wrx(8'h2C, 32'd0); wrx(8'h40, 32'd0); wrx(8'h44, 32'd0); wrx(8'h68, 32'd0);
    rdx(8'h34, '0, d); chk("R10 write ignored", d, {20'd0, STICKY});
    rdx(8'h40, '0, d);
    rdx(8'h34, '0, d); chk("R4 final clear", d, 32'd0);
    chk("R9 irq low", {31'd0, irq}, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule